// File: doc/BRIEF.md
# Hypervisor Trace Filter Control Register

This block holds a 32-bit control word that governs self-hosted trace filtering for the hypervisor privilege level. It also decides whether each software access to that word is allowed. Every read or write request carries the requester's privilege level (0 to 3) and the surrounding system state. The state inputs are the security state, whether level 2 is enabled, the hypervisor and monitor trap bits, a strap that gives "undefined" priority, and a qualifier that marks the undefined condition. The block answers each request in the same cycle with one of four outcomes: the access completes, the access is undefined, it traps to level 2, or it traps to level 3.

The stored word drives the effective trace permissions: level 2 tracing, level 0 tracing while host-trap-general is set, and VMID tracing. All of these are forced off when self-hosted trace is disabled. The word also selects the trace timestamp. The timestamp is either the raw physical counter or a virtual value, which is the counter minus an offset. An encoding in the word can instead defer the choice to a lower-level control input. Exception entry and the trace unit itself sit outside this block.

Top module: `hyp_trace_ctl`

## Requirements
- R1: After reset the stored word is zero, so a completed read returns 0 and all three trace permission outputs are 0.
- R2: Only bits 6,5,3,1,0 are storable (write mask 0x0000006B). All other bits read as 0, and writes to them are dropped.
- R3: Any request from level 0 gets outcome 01 (undefined).
- R4: A level 1 request gets outcome 10 (trap to level 2, syndrome 0x03) when level 2 is enabled and the hypervisor trap bit is set. Otherwise it gets 01.
- R5: For a level 2 request with the monitor trace trap bit clear, the outcome is 00. With that bit set, the outcome is 01 if the priority strap or the undefined qualifier is set, and 11 (trap to level 3) otherwise.
- R6: A level 3 request gets 01 in secure state (nonSecure=0) and 00 in non-secure state, whatever the trap bits are.
- R7: A write with outcome 00 updates the stored word at the next rising clock edge. A write with any other outcome leaves the word unchanged.
- R8: A read with outcome 00 returns the masked stored word on rdata in the request cycle. rdata is 0 for every other request.
- R9: The permission outputs are gated by selfHostedEn. trcLevel2En follows bit 1, vmidTraceEn follows bit 3, and trcLevel0En follows bit 0 AND hostTrapGeneral. All three are 0 while selfHostedEn is 0.
- R10: Bits 6:5 pick the timestamp. 01 gives physCount - virtOffset (modulo 2^CNT_W), and 11 gives physCount. 00 and 10 defer to lowerTsCtl, where 01 means virtual and any other value means physical. While selfHostedEn is 0 the field counts as 00.
- R11: respValid equals reqValid in the same cycle. The outcome code is 00 complete, 01 undefined, 10 trap to level 2, and 11 trap to level 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request strobe |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data |
| curLevel | input | 2 | Privilege level of the requester |
| nonSecure | input | 1 | 1 = non-secure state |
| lvl2Enabled | input | 1 | Level 2 is enabled |
| hypTrapT1 | input | 1 | Hypervisor trap bit for this register group |
| monTrapTrace | input | 1 | Monitor trace-register trap bit |
| undefPrio | input | 1 | Strap: undefined takes priority over the level 3 trap |
| undefCond | input | 1 | Undefined condition qualifier for the level 3 trap path |
| selfHostedEn | input | 1 | Self-hosted trace is enabled |
| hostTrapGeneral | input | 1 | Host-trap-general control |
| lowerTsCtl | input | 2 | Lower-level timestamp control |
| physCount | input | CNT_W | Physical counter |
| virtOffset | input | CNT_W | Virtual counter offset |
| respValid | output | 1 | Outcome strobe |
| respCode | output | 2 | Access outcome |
| rdata | output | 32 | Read data |
| trcLevel2En | output | 1 | Effective level 2 trace permission |
| trcLevel0En | output | 1 | Effective level 0 trace permission |
| vmidTraceEn | output | 1 | Effective VMID trace permission |
| tsValue | output | CNT_W | Selected timestamp |

## Verification
The bench builds the block with CNT_W at its default of 64. This makes the virtual timestamp subtraction run at full width. One case sets the offset above the counter, which exercises the borrow out of the top bit and the wrap to 2^64 - 5. The access-decision corners, including the level 2 priority ordering between undefined and the level 3 trap, come from a vector table. Directed writes then cover masking, blocked writes and every timestamp encoding.

// File: rtl/hyp_trace_pkg.sv
package hyp_trace_pkg;
  localparam int REG_W    = 32;
  localparam int BIT_L0   = 0;
  localparam int BIT_L2   = 1;
  localparam int BIT_VMID = 3;
  localparam int TS_LO    = 5;
  localparam logic [REG_W-1:0] WR_MASK = 32'h0000_006B;
  localparam logic [1:0] TS_VIRT = 2'b01;
  localparam logic [1:0] TS_PHYS = 2'b11;

  typedef enum logic [1:0] {
    RESP_DONE  = 2'b00,
    RESP_UNDEF = 2'b01,
    RESP_TRAP2 = 2'b10,
    RESP_TRAP3 = 2'b11
  } resp_e;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } ctl_strobe_t;
endpackage

// File: rtl/hyp_trace_access.sv
module hyp_trace_access
  import hyp_trace_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic [1:0]  curLevel,
  input  logic        nonSecure,
  input  logic        lvl2Enabled,
  input  logic        hypTrapT1,
  input  logic        monTrapTrace,
  input  logic        undefPrio,
  input  logic        undefCond,
  output logic        respValid,
  output resp_e       respCode,
  output ctl_strobe_t stb
);
  resp_e decision;

  always_comb begin
    unique case (curLevel)
      2'd0: decision = RESP_UNDEF;
      2'd1: decision = (lvl2Enabled && hypTrapT1) ? RESP_TRAP2 : RESP_UNDEF;
      2'd2: begin
        if (!monTrapTrace)          decision = RESP_DONE;
        else if (undefPrio)         decision = RESP_UNDEF;
        else if (undefCond)         decision = RESP_UNDEF;
        else                        decision = RESP_TRAP3;
      end
      default: decision = nonSecure ? RESP_DONE : RESP_UNDEF;
    endcase
  end

  assign respValid = reqValid;
  assign respCode  = reqValid ? decision : RESP_DONE;
  assign stb.wrStb = reqValid && reqWrite && (decision == RESP_DONE);
  assign stb.rdStb = reqValid && !reqWrite && (decision == RESP_DONE);
endmodule

// File: rtl/hyp_trace_regs.sv
module hyp_trace_regs
  import hyp_trace_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_strobe_t      stb,
  input  logic [REG_W-1:0] reqWdata,
  input  logic             selfHostedEn,
  input  logic             hostTrapGeneral,
  input  logic [1:0]       lowerTsCtl,
  input  logic [CNT_W-1:0] physCount,
  input  logic [CNT_W-1:0] virtOffset,
  output logic [REG_W-1:0] rdata,
  output logic             trcLevel2En,
  output logic             trcLevel0En,
  output logic             vmidTraceEn,
  output logic [CNT_W-1:0] tsValue
);
  logic [REG_W-1:0] ctlQ;
  logic [1:0]       tsField;
  logic [1:0]       tsSel;
  logic [CNT_W-1:0] virtTs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ctlQ <= '0;
    else if (stb.wrStb) ctlQ <= reqWdata & WR_MASK;
  end

  assign rdata = stb.rdStb ? ctlQ : '0;

  assign trcLevel2En = selfHostedEn && ctlQ[BIT_L2];
  assign vmidTraceEn = selfHostedEn && ctlQ[BIT_VMID];
  assign trcLevel0En = selfHostedEn && ctlQ[BIT_L0] && hostTrapGeneral;

  assign tsField = selfHostedEn ? ctlQ[TS_LO +: 2] : 2'b00;
  assign virtTs  = physCount - virtOffset;

  always_comb begin
    if (tsField == TS_VIRT || tsField == TS_PHYS) tsSel = tsField;
    else tsSel = (lowerTsCtl == TS_VIRT) ? TS_VIRT : TS_PHYS;
  end

  assign tsValue = (tsSel == TS_VIRT) ? virtTs : physCount;
endmodule

// File: rtl/hyp_trace_ctl.sv
module hyp_trace_ctl
  import hyp_trace_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqWdata,
  input  logic [1:0]       curLevel,
  input  logic             nonSecure,
  input  logic             lvl2Enabled,
  input  logic             hypTrapT1,
  input  logic             monTrapTrace,
  input  logic             undefPrio,
  input  logic             undefCond,
  input  logic             selfHostedEn,
  input  logic             hostTrapGeneral,
  input  logic [1:0]       lowerTsCtl,
  input  logic [CNT_W-1:0] physCount,
  input  logic [CNT_W-1:0] virtOffset,
  output logic             respValid,
  output logic [1:0]       respCode,
  output logic [31:0]      rdata,
  output logic             trcLevel2En,
  output logic             trcLevel0En,
  output logic             vmidTraceEn,
  output logic [CNT_W-1:0] tsValue
);
  ctl_strobe_t stb;
  resp_e       code;

  hyp_trace_access u_access (
    .reqValid(reqValid), .reqWrite(reqWrite), .curLevel(curLevel),
    .nonSecure(nonSecure), .lvl2Enabled(lvl2Enabled), .hypTrapT1(hypTrapT1),
    .monTrapTrace(monTrapTrace), .undefPrio(undefPrio), .undefCond(undefCond),
    .respValid(respValid), .respCode(code), .stb(stb)
  );

  assign respCode = code;

  hyp_trace_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .reqWdata(reqWdata),
    .selfHostedEn(selfHostedEn), .hostTrapGeneral(hostTrapGeneral),
    .lowerTsCtl(lowerTsCtl), .physCount(physCount), .virtOffset(virtOffset),
    .rdata(rdata), .trcLevel2En(trcLevel2En), .trcLevel0En(trcLevel0En),
    .vmidTraceEn(vmidTraceEn), .tsValue(tsValue)
  );
endmodule

// File: rtl/hyp_trace_ctl_chk.sv
module hyp_trace_ctl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [1:0]  curLevel,
  input logic        nonSecure,
  input logic        lvl2Enabled,
  input logic        hypTrapT1,
  input logic        monTrapTrace,
  input logic        undefPrio,
  input logic        undefCond,
  input logic        selfHostedEn,
  input logic        hostTrapGeneral,
  input logic        respValid,
  input logic [1:0]  respCode,
  input logic [31:0] rdata,
  input logic        trcLevel2En,
  input logic        trcLevel0En,
  input logic        vmidTraceEn
);
  p_level0_undef_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && curLevel == 2'd0 |-> respCode == 2'b01);

  p_level1_trap_r4: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && curLevel == 2'd1 && lvl2Enabled && hypTrapT1 |-> respCode == 2'b10);

  p_level2_prio_r5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && curLevel == 2'd2 && monTrapTrace && undefPrio |-> respCode == 2'b01);

  p_level3_secure_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && curLevel == 2'd3 && !nonSecure |-> respCode == 2'b01);

  p_blocked_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqWrite && respCode != 2'b00 ##1 $stable(selfHostedEn) && $stable(hostTrapGeneral)
    |-> $stable(trcLevel2En) && $stable(vmidTraceEn) && $stable(trcLevel0En));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdata & ~32'h0000_006B) == 32'h0);

  p_rdata_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid || reqWrite || respCode != 2'b00 |-> rdata == 32'h0);

  p_gated_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !selfHostedEn |-> !trcLevel2En && !trcLevel0En && !vmidTraceEn);

  p_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    respValid == reqValid);
endmodule

bind hyp_trace_ctl hyp_trace_ctl_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .curLevel(curLevel), .nonSecure(nonSecure), .lvl2Enabled(lvl2Enabled),
  .hypTrapT1(hypTrapT1), .monTrapTrace(monTrapTrace), .undefPrio(undefPrio),
  .undefCond(undefCond), .selfHostedEn(selfHostedEn),
  .hostTrapGeneral(hostTrapGeneral), .respValid(respValid),
  .respCode(respCode), .rdata(rdata), .trcLevel2En(trcLevel2En),
  .trcLevel0En(trcLevel0En), .vmidTraceEn(vmidTraceEn)
);

// File: tb/hyp_trace_ctl_tb.sv
`timescale 1ns/1ps
module hyp_trace_ctl_tb;
  localparam int CNT_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic [1:0] curLevel = 2'd3;
  logic nonSecure = 1'b1, lvl2Enabled = 1'b0, hypTrapT1 = 1'b0;
  logic monTrapTrace = 1'b0, undefPrio = 1'b0, undefCond = 1'b0;
  logic selfHostedEn = 1'b1, hostTrapGeneral = 1'b1;
  logic [1:0] lowerTsCtl = 2'b00;
  logic [CNT_W-1:0] physCount = 64'd1000, virtOffset = 64'd300;
  logic respValid;
  logic [1:0] respCode;
  logic [31:0] rdata;
  logic trcLevel2En, trcLevel0En, vmidTraceEn;
  logic [CNT_W-1:0] tsValue;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  hyp_trace_ctl #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .curLevel(curLevel), .nonSecure(nonSecure),
    .lvl2Enabled(lvl2Enabled), .hypTrapT1(hypTrapT1),
    .monTrapTrace(monTrapTrace), .undefPrio(undefPrio), .undefCond(undefCond),
    .selfHostedEn(selfHostedEn), .hostTrapGeneral(hostTrapGeneral),
    .lowerTsCtl(lowerTsCtl), .physCount(physCount), .virtOffset(virtOffset),
    .respValid(respValid), .respCode(respCode), .rdata(rdata),
    .trcLevel2En(trcLevel2En), .trcLevel0En(trcLevel0En),
    .vmidTraceEn(vmidTraceEn), .tsValue(tsValue)
  );

  // {level[9:8], ns[7], l2en[6], t1[5], mon[4], prio[3], ucond[2], expected[1:0]}
  localparam logic [9:0] VEC [12] = '{
    10'b00_1_1_1_0_0_0_01,  // R3 level 0
    10'b01_1_1_1_0_0_0_10,  // R4 trap to 2
    10'b01_1_0_1_0_0_0_01,  // R4 level 2 disabled
    10'b01_1_1_0_0_0_0_01,  // R4 trap bit clear
    10'b10_1_0_0_0_1_1_00,  // R5 trap clear completes
    10'b10_1_0_0_1_1_0_01,  // R5 priority strap
    10'b10_1_0_0_1_0_1_01,  // R5 undefined qualifier
    10'b10_1_0_0_1_0_0_11,  // R5 trap to 3
    10'b11_0_0_0_0_0_0_01,  // R6 secure
    10'b11_1_0_0_0_0_0_00,  // R6 non-secure
    10'b11_1_1_1_1_1_1_00,  // R6 trap bits irrelevant
    10'b10_0_0_0_0_0_0_00   // R5 secure level 2
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic setCtx(input logic [1:0] lvl, input logic ns, input logic l2,
                        input logic t1, input logic mon, input logic pr,
                        input logic uc);
    curLevel = lvl; nonSecure = ns; lvl2Enabled = l2; hypTrapT1 = t1;
    monTrapTrace = mon; undefPrio = pr; undefCond = uc;
  endtask

  // Issue one write in the current context; returns the observed code.
  task automatic doWrite(input logic [31:0] d, output logic [1:0] code);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqWdata = d;
    #1 code = respCode;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  // Issue one read in the current context; sampled mid-cycle.
  task automatic doRead(output logic [31:0] d, output logic [1:0] code);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0;
    #1 d = rdata; code = respCode;
    check(respValid == 1'b1, "R11 respValid", respValid, 1);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [1:0] cd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    setCtx(2'd3, 1, 0, 0, 0, 0, 0);
    doRead(rd, cd);
    check(rd == 32'h0 && cd == 2'b00, "R1 reset read", rd, 0);
    check({trcLevel2En, trcLevel0En, vmidTraceEn} == 3'b000, "R1 reset enables",
          {trcLevel2En, trcLevel0En, vmidTraceEn}, 0);
    check(respValid == 1'b0, "R11 idle strobe", respValid, 0);

    // Decision table (register is zero: completed reads give 0)
    for (int i = 0; i < 12; i++) begin
      setCtx(VEC[i][9:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4],
             VEC[i][3], VEC[i][2]);
      doRead(rd, cd);
      check(cd == VEC[i][1:0], "R3/R4/R5/R6 outcome table", cd, VEC[i][1:0]);
      if (VEC[i][1:0] != 2'b00)
        check(rd == 32'h0, "R8 rdata zero on refused read", rd, 0);
    end

    // Masked write then read back
    setCtx(2'd3, 1, 0, 0, 0, 0, 0);
    doWrite(32'hFFFF_FFFF, cd);
    check(cd == 2'b00, "R7 write completes", cd, 0);
    doRead(rd, cd);
    check(rd == 32'h0000_006B, "R2 reserved bits dropped", rd, 32'h6B);
    check({trcLevel2En, trcLevel0En, vmidTraceEn} == 3'b111, "R9 all enabled",
          {trcLevel2En, trcLevel0En, vmidTraceEn}, 3'b111);
    check(tsValue == 64'd1000, "R10 field 11 physical", tsValue, 1000);
    #1 hostTrapGeneral = 1'b0; #1;
    check(trcLevel0En == 1'b0 && trcLevel2En == 1'b1, "R9 level 0 needs host-trap-general",
          {trcLevel2En, trcLevel0En}, 2'b10);
    hostTrapGeneral = 1'b1;
    selfHostedEn = 1'b0; lowerTsCtl = 2'b01; #1;
    check({trcLevel2En, trcLevel0En, vmidTraceEn} == 3'b000, "R9 self-hosted off",
          {trcLevel2En, trcLevel0En, vmidTraceEn}, 0);
    check(tsValue == 64'd700, "R10 self-hosted off defers", tsValue, 700);
    selfHostedEn = 1'b1; lowerTsCtl = 2'b00;

    // Blocked writes leave the word unchanged
    setCtx(2'd1, 1, 1, 1, 0, 0, 0);
    doWrite(32'h0, cd);
    check(cd == 2'b10, "R7 level 1 trap write code", cd, 2'b10);
    setCtx(2'd2, 1, 0, 0, 1, 0, 0);
    doWrite(32'h0, cd);
    check(cd == 2'b11, "R7 level 3 trap write code", cd, 2'b11);
    setCtx(2'd0, 1, 0, 0, 0, 0, 0);
    doWrite(32'h0, cd);
    setCtx(2'd3, 1, 0, 0, 0, 0, 0);
    doRead(rd, cd);
    check(rd == 32'h0000_006B, "R7 refused writes ignored", rd, 32'h6B);

    // Level 2 completed write; virtual timestamp
    setCtx(2'd2, 1, 0, 0, 0, 0, 0);
    doWrite(32'h0000_0022, cd);
    check(cd == 2'b00, "R5 level 2 write completes", cd, 0);
    doRead(rd, cd);
    check(rd == 32'h22, "R8 readback after write", rd, 32'h22);
    check(tsValue == 64'd700, "R10 field 01 virtual", tsValue, 700);
    check(vmidTraceEn == 1'b0 && trcLevel2En == 1'b1, "R9 single bits",
          {vmidTraceEn, trcLevel2En}, 2'b01);
    physCount = 64'd5; virtOffset = 64'd10; #1;
    check(tsValue == 64'hFFFF_FFFF_FFFF_FFFB, "R10 virtual wrap", tsValue,
          64'hFFFF_FFFF_FFFF_FFFB);
    physCount = 64'd1000; virtOffset = 64'd300;

    // Field 10 and 00 defer to the lower control
    doWrite(32'h0000_0040, cd);
    lowerTsCtl = 2'b11; #1;
    check(tsValue == 64'd1000, "R10 field 10 lower physical", tsValue, 1000);
    lowerTsCtl = 2'b01; #1;
    check(tsValue == 64'd700, "R10 field 10 lower virtual", tsValue, 700);
    doWrite(32'h0000_0000, cd);
    lowerTsCtl = 2'b10; #1;
    check(tsValue == 64'd1000, "R10 field 00 lower other", tsValue, 1000);

    // Write takes effect only after the edge
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqWdata = 32'h2;
    #1 check(trcLevel2En == 1'b0, "R7 not before edge", trcLevel2En, 0);
    @(posedge clk); #1;
    check(trcLevel2En == 1'b1, "R7 after edge", trcLevel2En, 1);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule